// File: doc/BRIEF.md
# Pixel Readout Frame Stream Generator

This block stands in for the readout link of a pixel chip during bench and system tests. Once triggered, it plays out a fixed burst of 16-bit words grouped into four-word frames. Every frame carries two control words followed by two data words. A three-bit side channel tells a receiver which kind of word is on the bus. The burst opens with an event frame, continues with one frame per hit-data pair, and closes with a few idle frames. Between bursts the generator keeps sending idle frames, so a receiver never loses frame lock.

Words advance only on cycles where the pacing enable is high. This lets the link rate be set by a slower external strobe while the block runs on the system clock. Hit payload comes from an internal word memory that the test loads through a simple write port before it triggers. A stepped mode lets the test freeze the burst at its opening: the first eight words replay until a second trigger lets the rest of the burst through.

Top module: `pixfrm_gen`

## Requirements
- R1: While `rst_ni` is low, `word_o` and `side_o` are zero. The background idle phase then restarts at control slot 0.
- R2: With no burst active, every paced word is 0x0000. `side_o` repeats the slot pattern 4, 4, 0, 0: the control flag (bit 2, value 4) is set on the two control slots, and the data flag is clear.
- R3: While `pace_i` is low, `word_o` and `side_o` hold their values. The word sequence then resumes at the next word, with none skipped.
- R4: A trigger edge arms a burst. The burst starts on the first paced word that opens a new idle frame, within four paced words of the trigger. It is exactly 4*(1+HIT_FRAMES+IDLE_FRAMES) words long: 1040 at the default settings.
- R5: In a burst, `side_o` is 4 on slots 0 and 1 of every frame. It is 2 (data flag, bit 1) on slots 2 and 3 of the event frame and of the hit frames, and 0 on slots 2 and 3 of the closing idle frames. Bit 0 is never set, and the two flags are never set together.
- R6: The event frame carries 0xC000 in slot 0 and the burst number (zero-extended, 8 bits) in slots 1 and 2, and 0x0000 in slot 3. The burst number is 0 after reset and rises by one after each completed burst.
- R7: Hit frame h (0-based) carries the burst number in slot 1. Slot 0 carries 0x3000 (bits 13:12) in hit frame 0 only, and 0x0C00 (bits 11:10) in the last hit frame only. In every other hit frame, slot 0 is 0x0000.
- R8: A write with `ld_we_i` high stores `ld_data_i` at `ld_addr_i`. Hit frame h sends memory word 2h in slot 2 and word 2h+1 in slot 3.
- R9: If `step_i` is high when a burst starts, words 0 to 7 replay in a loop. A later trigger edge lets the burst continue from word 8 after the next word 7.
- R10: Trigger edges during a running burst have no effect, except for the release in R9. After the last idle frame of the burst, background idle frames follow at once, starting at slot 0.
- R11: Triggers are edge-sensitive. Holding `trig_i` high starts only one burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pace_i | input | 1 | Word-rate enable; one word is emitted per high cycle |
| trig_i | input | 1 | Trigger; a rising edge arms a burst or releases the stepped hold |
| step_i | input | 1 | Stepped mode select, sampled when a burst starts |
| ld_we_i | input | 1 | Hit memory write enable |
| ld_addr_i | input | 9 | Hit memory write address |
| ld_data_i | input | 16 | Hit memory write data |
| word_o | output | 16 | Emitted link word |
| side_o | output | 3 | Side flags: bit 2 control word, bit 1 data word, bit 0 zero |

## Verification
The embedded properties assume that `pace_i` and `trig_i` are defined and synchronous after reset. They also assume that reset is held for several cycles, so the hold property never compares against a pre-reset output. The stimulus drives every input on the falling edge and holds reset for four cycles. It also holds `step_i` steady around each trigger, so a property never sees a mode change partway through a burst. It never writes the hit memory while a burst is running, so the payload that the properties and the checks see cannot change mid-burst.

// File: rtl/pixfrm_pkg.sv
`timescale 1ns/1ps
package pixfrm_pkg;

    localparam int WORD_W = 16;
    localparam int SIDE_W = 3;

    localparam logic [WORD_W-1:0] EVT_MARK   = 16'hC000;
    localparam logic [WORD_W-1:0] FIRST_MARK = 16'h3000;
    localparam logic [WORD_W-1:0] LAST_MARK  = 16'h0C00;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } sq_state_e;

endpackage

// File: rtl/pixfrm_hitbuf.sv
`timescale 1ns/1ps
module pixfrm_hitbuf #(
    parameter int DEPTH  = 512,
    parameter int WORD_W = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/pixfrm_seq.sv
`timescale 1ns/1ps
module pixfrm_seq
    import pixfrm_pkg::*;
#(
    parameter int TOTAL_WORDS = 1040,
    parameter int HOLD_WORDS  = 8,
    parameter int EVT_W       = 8,
    parameter int IDX_W       = $clog2(TOTAL_WORDS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pace_i,
    input  logic             trig_i,
    input  logic             step_i,
    output logic             emit_seq_o,
    output logic [IDX_W-1:0] emit_idx_o,
    output logic [1:0]       islot_o,
    output logic [EVT_W-1:0] evt_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);
    localparam logic [IDX_W-1:0] HOLD_END = IDX_W'(HOLD_WORDS - 1);
    localparam logic [IDX_W-1:0] HOLD_LIM = IDX_W'(HOLD_WORDS);

    typedef struct packed {
        sq_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [1:0]       islot;
        logic             pend;
        logic             step;
        logic             rel;
        logic             trig;
        logic [EVT_W-1:0] evt;
    } seq_t;

    seq_t s_q, s_d;
    logic trig_rise;
    logic rel_take;
    logic rel_now;
    logic start;

    always_comb begin
        s_d        = s_q;
        trig_rise  = trig_i & ~s_q.trig;
        s_d.trig   = trig_i;
        rel_take   = trig_rise && (s_q.state == SQ_RUN) && s_q.step
                     && !s_q.rel && (s_q.idx < HOLD_LIM);
        rel_now    = s_q.rel | rel_take;
        s_d.rel    = rel_now;
        start      = 1'b0;
        emit_seq_o = 1'b0;
        emit_idx_o = s_q.idx;

        case (s_q.state)
            SQ_IDLE: begin
                s_d.pend = s_q.pend | trig_rise;
                if (pace_i) begin
                    if (s_q.pend && (s_q.islot == 2'd0)) begin
                        start      = 1'b1;
                        emit_seq_o = 1'b1;
                        emit_idx_o = '0;
                        s_d.state  = SQ_RUN;
                        s_d.idx    = IDX_W'(1);
                        s_d.pend   = 1'b0;
                        s_d.step   = step_i;
                        s_d.rel    = 1'b0;
                    end else begin
                        s_d.islot = s_q.islot + 2'd1;
                    end
                end
            end
            SQ_RUN: begin
                emit_seq_o = 1'b1;
                if (pace_i) begin
                    if (s_q.idx == LAST_IDX) begin
                        s_d.state = SQ_IDLE;
                        s_d.idx   = '0;
                        s_d.islot = 2'd0;
                        s_d.evt   = s_q.evt + 1'b1;
                    end else if (s_q.step && !rel_now && (s_q.idx == HOLD_END)) begin
                        s_d.idx = '0;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q       <= '0;
            s_q.state <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign islot_o = s_q.islot;
    assign evt_o   = s_q.evt;

    // R4
    start_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.state == SQ_RUN) |-> ($past(s_q.islot) == 2'd0) && $past(s_q.pend));

    // R9
    nostep_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == SQ_RUN && !s_q.step && pace_i && s_q.idx != LAST_IDX)
        |=> (s_q.idx == $past(s_q.idx) + 1'b1));

    // R10
    busy_no_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.state == SQ_RUN) |=> !s_q.pend);

endmodule

// File: rtl/pixfrm_fmt.sv
`timescale 1ns/1ps
module pixfrm_fmt
    import pixfrm_pkg::*;
#(
    parameter int HIT_FRAMES = 256,
    parameter int EVT_W      = 8,
    parameter int IDX_W      = 11,
    parameter int ADDR_W     = $clog2(2 * HIT_FRAMES)
) (
    input  logic              emit_seq_i,
    input  logic [IDX_W-1:0]  emit_idx_i,
    input  logic [1:0]        islot_i,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic [WORD_W-1:0] word_o,
    output logic [SIDE_W-1:0] side_o
);

    localparam int FR_W = IDX_W - 2;
    localparam int HB   = ADDR_W - 1;
    localparam logic [FR_W-1:0] LAST_HIT = FR_W'(HIT_FRAMES);

    logic [1:0]        slot;
    logic [FR_W-1:0]   frame;
    logic [FR_W-1:0]   hit_idx;
    logic [WORD_W-1:0] evt_word;
    logic              cav;
    logic              dav;
    logic              unused_hi;

    assign evt_word  = {{(WORD_W - EVT_W){1'b0}}, evt_i};
    assign unused_hi = ^hit_idx[FR_W-1:HB];

    always_comb begin
        slot      = emit_seq_i ? emit_idx_i[1:0] : islot_i;
        frame     = emit_idx_i[IDX_W-1:2];
        hit_idx   = frame - 1'b1;
        rd_addr_o = {hit_idx[HB-1:0], slot[0]};
        word_o    = '0;
        cav       = ~slot[1];
        dav       = 1'b0;

        if (emit_seq_i) begin
            if (frame == '0) begin
                dav = slot[1];
                case (slot)
                    2'd0:    word_o = EVT_MARK;
                    2'd1:    word_o = evt_word;
                    2'd2:    word_o = evt_word;
                    default: word_o = '0;
                endcase
            end else if (frame <= LAST_HIT) begin
                dav = slot[1];
                case (slot)
                    2'd0: begin
                        if (frame == FR_W'(1)) word_o = word_o | FIRST_MARK;
                        if (frame == LAST_HIT) word_o = word_o | LAST_MARK;
                    end
                    2'd1:    word_o = evt_word;
                    default: word_o = rd_data_i;
                endcase
            end
        end

        side_o = {cav, dav, 1'b0};
    end

endmodule

// File: rtl/pixfrm_gen.sv
`timescale 1ns/1ps
module pixfrm_gen
    import pixfrm_pkg::*;
#(
    parameter int HIT_FRAMES  = 256,
    parameter int IDLE_FRAMES = 3,
    parameter int HOLD_WORDS  = 8,
    parameter int EVT_W       = 8
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            pace_i,
    input  logic                            trig_i,
    input  logic                            step_i,
    input  logic                            ld_we_i,
    input  logic [$clog2(2*HIT_FRAMES)-1:0] ld_addr_i,
    input  logic [15:0]                     ld_data_i,
    output logic [15:0]                     word_o,
    output logic [2:0]                      side_o
);

    localparam int TOTAL_WORDS = 4 * (1 + HIT_FRAMES + IDLE_FRAMES);
    localparam int IDX_W       = $clog2(TOTAL_WORDS);
    localparam int MEM_DEPTH   = 2 * HIT_FRAMES;
    localparam int ADDR_W      = $clog2(MEM_DEPTH);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [SIDE_W-1:0] side;
    } out_t;

    logic              emit_seq;
    logic [IDX_W-1:0]  emit_idx;
    logic [1:0]        islot;
    logic [EVT_W-1:0]  evt;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic [WORD_W-1:0] fmt_word;
    logic [SIDE_W-1:0] fmt_side;
    out_t              o_q, o_d;

    pixfrm_seq #(
        .TOTAL_WORDS (TOTAL_WORDS),
        .HOLD_WORDS  (HOLD_WORDS),
        .EVT_W       (EVT_W),
        .IDX_W       (IDX_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pace_i     (pace_i),
        .trig_i     (trig_i),
        .step_i     (step_i),
        .emit_seq_o (emit_seq),
        .emit_idx_o (emit_idx),
        .islot_o    (islot),
        .evt_o      (evt)
    );

    pixfrm_hitbuf #(
        .DEPTH  (MEM_DEPTH),
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_hitbuf (
        .clk_i   (clk_i),
        .we_i    (ld_we_i),
        .waddr_i (ld_addr_i),
        .wdata_i (ld_data_i),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    pixfrm_fmt #(
        .HIT_FRAMES (HIT_FRAMES),
        .EVT_W      (EVT_W),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W)
    ) u_fmt (
        .emit_seq_i (emit_seq),
        .emit_idx_i (emit_idx),
        .islot_i    (islot),
        .evt_i      (evt),
        .rd_data_i  (rd_data),
        .rd_addr_o  (rd_addr),
        .word_o     (fmt_word),
        .side_o     (fmt_side)
    );

    always_comb begin
        o_d = o_q;
        if (pace_i) begin
            o_d.word = fmt_word;
            o_d.side = fmt_side;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign word_o = o_q.word;
    assign side_o = o_q.side;

    // R3
    pace_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(pace_i) |-> ($stable(word_o) && $stable(side_o)));

    // R5
    flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(side_o[2] && side_o[1]) && !side_o[0]);

    generate
        if (HIT_FRAMES > 1) begin : g_mark_chk
            // R7
            mark_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (side_o == 3'd4 && word_o[13:12] != 2'b00) |-> (word_o[11:10] == 2'b00));
        end
    endgenerate

endmodule

// File: tb/pixfrm_gen_tb.sv
`timescale 1ns/1ps
module pixfrm_gen_tb;

    localparam int    HIT    = 256;
    localparam int    IDLEF  = 3;
    localparam int    TOTAL  = 4 * (1 + HIT + IDLEF);
    localparam int    CAP    = 2400;
    localparam real   CLK_NS = 4.0;
    localparam int    WD_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pace;
    logic        trig;
    logic        step;
    logic        ld_we;
    logic [8:0]  ld_addr;
    logic [15:0] ld_data;
    logic [15:0] word;
    logic [2:0]  side;

    logic [15:0] cw [0:CAP-1];
    logic [2:0]  cs [0:CAP-1];

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    pixfrm_gen u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .pace_i    (pace),
        .trig_i    (trig),
        .step_i    (step),
        .ld_we_i   (ld_we),
        .ld_addr_i (ld_addr),
        .ld_data_i (ld_data),
        .word_o    (word),
        .side_o    (side)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_pat(input int a);
        return 16'((a * 40503) ^ 23130);
    endfunction

    function automatic logic [15:0] exp_word(input int p, input int evt);
        int f = p / 4;
        int sl = p % 4;
        logic [15:0] w = 16'h0000;
        if (f == 0) begin
            if (sl == 0) w = 16'hC000;
            else if (sl == 1 || sl == 2) w = 16'(evt);
        end else if (f <= HIT) begin
            if (sl == 0) begin
                if (f == 1)   w = w | 16'h3000;
                if (f == HIT) w = w | 16'h0C00;
            end else if (sl == 1) begin
                w = 16'(evt);
            end else begin
                w = mem_pat(2 * (f - 1) + (sl - 2));
            end
        end
        return w;
    endfunction

    function automatic logic [2:0] exp_side(input int p);
        int f = p / 4;
        int sl = p % 4;
        if (sl < 2) return 3'd4;
        if (f <= HIT) return 3'd2;
        return 3'd0;
    endfunction

    task automatic capture(input int n, input int t1, input int t2, input bit hold_hi);
        for (int i = 0; i < n; i++) begin
            trig = (i == t1) || (i == t2) || (hold_hi && i >= t1);
            @(posedge clk);
            @(negedge clk);
            cw[i] = word;
            cs[i] = side;
        end
        trig = 1'b0;
    endtask

    task automatic verify(input string tag, input bit stepped, input int t_rel,
                          input int evt, input int n);
        int s = -1;
        int p = 0;
        int j = 0;
        int marks = 0;
        bit ok;
        int e [5];
        int fa [5];
        int fe [5];
        for (int k = 0; k < 5; k++) begin
            e[k] = 0; fa[k] = 0; fe[k] = 0;
        end
        for (int k = 0; k < n; k++) begin
            if (s < 0 && cw[k] == 16'hC000 && cs[k] == 3'd4) s = k;
        end
        ok = (s >= 1 && s <= 4) ? (cs[s-1] == 3'd0) : 1'b0;
        chk(ok, "R4", {tag, " start within one idle frame"}, s, 1);
        if (s < 0) return;
        j = s;
        while (p < TOTAL && j < n) begin
            int f = p / 4;
            int sl = p % 4;
            int cat = (f == 0) ? 0 : (f <= HIT) ? ((sl < 2) ? 1 : 2) : 3;
            if (cw[j] != exp_word(p, evt)) begin
                if (e[cat] == 0) begin fa[cat] = int'(cw[j]); fe[cat] = int'(exp_word(p, evt)); end
                e[cat]++;
            end
            if (cs[j] != exp_side(p)) begin
                if (e[4] == 0) begin fa[4] = int'(cs[j]); fe[4] = int'(exp_side(p)); end
                e[4]++;
            end
            if (stepped && p == 7 && !(t_rel <= j)) p = 0;
            else p++;
            j++;
        end
        chk(p == TOTAL, "R4", {tag, " burst length in words"}, p, TOTAL);
        chk(e[0] == 0, "R6", {tag, " event frame"}, fa[0], fe[0]);
        chk(e[1] == 0, "R7", {tag, " hit control words"}, fa[1], fe[1]);
        chk(e[2] == 0, "R8", {tag, " hit data words"}, fa[2], fe[2]);
        chk(e[3] == 0, "R10", {tag, " closing idle frames"}, fa[3], fe[3]);
        chk(e[4] == 0, "R5", {tag, " side flags"}, fa[4], fe[4]);
        ok = (j + 4 <= n);
        for (int k = 0; k < 4 && ok; k++) begin
            if (cw[j+k] != 16'h0000 || cs[j+k] != ((k < 2) ? 3'd4 : 3'd0)) ok = 1'b0;
        end
        chk(ok, "R10", {tag, " background idle after burst"}, ok, 1);
        for (int k = j; k < n; k++) begin
            if (cw[k] == 16'hC000 && cs[k] == 3'd4) marks++;
        end
        chk(marks == 0, "R11", {tag, " no second burst"}, marks, 0);
        if (stepped) begin
            chk((j - s) > TOTAL && ((j - s - TOTAL) % 8) == 0, "R9",
                {tag, " opening words replayed before release"}, j - s - TOTAL, 8);
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; pace = 1'b1; trig = 1'b0; step = 1'b0;
        ld_we = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(word == 16'h0000, "R1", "word in reset", word, 0);
        chk(side == 3'd0, "R1", "side in reset", side, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle_hold;
        logic [15:0] hw;
        logic [2:0]  hs;
        bit ok = 1'b1;
        bit okw = 1'b1;
        capture(8, -1, -1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            if (cs[k] != ((k % 4 < 2) ? 3'd4 : 3'd0)) ok = 1'b0;
            if (cw[k] != 16'h0000) okw = 1'b0;
        end
        chk(ok, "R2", "idle side pattern from slot 0", cs[2], 0);
        chk(okw, "R2", "idle words zero", cw[0], 0);
        hw = word; hs = side;
        pace = 1'b0;
        ok = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (word != hw || side != hs) ok = 1'b0;
        end
        chk(ok, "R3", "outputs held with pace low", side, hs);
        pace = 1'b1;
        capture(4, -1, -1, 1'b0);
        ok = (cs[0] == 3'd4) && (cs[1] == 3'd4) && (cs[2] == 3'd0) && (cs[3] == 3'd0);
        chk(ok, "R3", "idle phase resumes without skip", cs[0], 4);
    endtask

    task automatic t_load;
        for (int a = 0; a < 2 * HIT; a++) begin
            ld_we = 1'b1; ld_addr = 9'(a); ld_data = mem_pat(a);
            @(posedge clk);
            @(negedge clk);
        end
        ld_we = 1'b0;
    endtask

    task automatic t_plain;
        step = 1'b0;
        capture(1100, 0, -1, 1'b0);
        verify("plain", 1'b0, -1, 0, 1100);
    endtask

    task automatic t_busy_trig;
        step = 1'b0;
        capture(1100, 0, 300, 1'b0);
        verify("trigger while busy", 1'b0, -1, 1, 1100);
    endtask

    task automatic t_stepped;
        step = 1'b1;
        capture(1200, 0, 40, 1'b0);
        step = 1'b0;
        verify("stepped", 1'b1, 40, 2, 1200);
    endtask

    task automatic t_level;
        step = 1'b0;
        capture(2200, 0, -1, 1'b1);
        verify("level trigger", 1'b0, -1, 3, 2200);
    endtask

    initial begin
        #(WD_CYC * CLK_NS);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", WD_CYC, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_hold();
        t_load();
        t_plain();
        t_busy_trig();
        t_stepped();
        t_level();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule